// File: doc/BRIEF.md
# Parallel Control-Word Loader

This block is the processor-facing loading stage of a numerically controlled oscillator. A host drives a 16-bit data bus and a 3-bit address, then pulses an active-low write strobe. The block holds the bus contents present at the end of that pulse. On the next rising edge of the oscillator clock it writes them into one of six stored control words. Two of these are 32-bit frequency steps and four are 12-bit phase offsets. The stored words leave the block as plain outputs and feed the accumulator and phase adder downstream.

Each frequency step is too wide for the bus, so it is split into a low half and a high half. Each half has its own address, and either half can be rewritten without disturbing the other. The phase offsets use only the low twelve data bits. Reset touches only the strobe-tracking logic and never the stored words. Software can therefore reset the oscillator phase without reloading its settings.

Top module: `ctrl_word_loader`

## Requirements
- R1: A write takes the 16-bit data and the 3-bit address that are on the bus at the rising edge of the active-low strobe `wr_n`. Bus changes after that edge have no effect on the write.
- R2: Address 0 loads bits 15:0 of frequency step 0, and address 1 loads its bits 31:16. Address 2 loads bits 15:0 of frequency step 1, and address 3 loads its bits 31:16.
- R3: A write changes exactly one register field. A half-word write leaves the other 16 bits of the same frequency step unchanged.
- R4: Addresses 4, 5, 6 and 7 load phase offsets 0, 1, 2 and 3 from data bits 11:0. Data bits 15:12 are ignored.
- R5: The new value appears at the outputs on the first rising clock edge after the strobe's rising edge. Before that edge the old value is still shown.
- R6: Writes can be issued back to back, one per clock cycle, and every one of them lands.
- R7: Asserting `rst_n` low leaves all frequency and phase registers unchanged.
- R8: While `wr_n` stays high, activity on the data and address buses changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; registers update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the strobe tracking only |
| wr_n | input | 1 | Active-low write strobe; its rising edge captures the bus |
| bus_data | input | 16 | Write data |
| bus_addr | input | 3 | Destination select |
| freq_word | output | 2x32 | Stored frequency steps, index 0 and 1 |
| phase_word | output | 4x12 | Stored phase offsets, index 0 to 3 |

## Verification
A fixed sequence loads every address with a known pattern, assembles frequency steps with the high half first and with the low half first, and then rewrites a single half. This shows whether the halves are routed to the correct bits and whether the untouched half is preserved.

Phase writes carry ones in data bits 15:12, which exposes any leakage of those bits into the stored value. A burst of one write per cycle across all eight addresses, followed by a run of random writes, distinguishes correct one-cycle commit timing from lost or late updates. Each write is checked just before its commit edge and again just after it.

Bus activity with the strobe held high, and a reset pulse in the middle of the run, must both leave all six registers as they were.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   // Number of address bits needed to reach every slot (at least one).
   function automatic int addr_bits(input int slots);
      return (slots < 2) ? 1 : $clog2(slots);
   endfunction

endpackage

// File: rtl/ldr_strobe_capture.sv
module ldr_strobe_capture #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              commit,
   output logic [DATA_W-1:0] held_data,
   output logic [ADDR_W-1:0] held_addr
);

   logic wr_tog;
   logic tog_seen;

   // Strobe domain: hold the bus and flip a flag on every completed write.
   always_ff @(posedge wr_n or negedge rst_n) begin
      if (!rst_n) wr_tog <= 1'b0;
      else        wr_tog <= ~wr_tog;
   end

   always_ff @(posedge wr_n) begin
      held_data <= bus_data;
      held_addr <= bus_addr;
   end

   // Clock domain: a flag mismatch marks a write still waiting to be committed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_seen <= 1'b0;
      else        tog_seen <= wr_tog;
   end

   assign commit = wr_tog ^ tog_seen;

endmodule

// File: rtl/ldr_slot_decode.sv
module ldr_slot_decode #(
   parameter int ADDR_W  = 3,
   parameter int N_SLOTS = 8
)(
   input  logic               commit,
   input  logic [ADDR_W-1:0]  held_addr,
   output logic [N_SLOTS-1:0] slot_we
);

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      assign slot_we[s] = commit && (held_addr == ADDR_W'(s));
   end

endmodule

// File: rtl/ldr_word_store.sv
module ldr_word_store #(
   parameter int DATA_W  = 16,
   parameter int FREQ_W  = 32,
   parameter int PHASE_W = 12,
   parameter int N_FREQ  = 2,
   parameter int N_PHASE = 4,
   localparam int HALVES       = FREQ_W / DATA_W,
   localparam int N_FREQ_SLOTS = N_FREQ * HALVES,
   localparam int N_SLOTS      = N_FREQ_SLOTS + N_PHASE
)(
   input  logic                             clk,
   input  logic [N_SLOTS-1:0]               slot_we,
   input  logic [DATA_W-1:0]                held_data,
   output logic [N_FREQ-1:0][FREQ_W-1:0]    freq_word,
   output logic [N_PHASE-1:0][PHASE_W-1:0]  phase_word
);

   logic [PHASE_W-1:0] phase_data;

   if (PHASE_W == DATA_W) begin : g_phase_full
      assign phase_data = held_data;
   end else begin : g_phase_trunc
      assign phase_data = held_data[PHASE_W-1:0];
   end

   // No reset: stored words survive a reset of the strobe logic.
   always_ff @(posedge clk) begin
      for (int s = 0; s < N_FREQ_SLOTS; s++) begin
         if (slot_we[s])
            freq_word[s / HALVES][(s % HALVES) * DATA_W +: DATA_W] <= held_data;
      end
      for (int p = 0; p < N_PHASE; p++) begin
         if (slot_we[N_FREQ_SLOTS + p])
            phase_word[p] <= phase_data;
      end
   end

endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
   import ldr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int FREQ_W  = 32,
   parameter int PHASE_W = 12,
   parameter int N_FREQ  = 2,
   parameter int N_PHASE = 4,
   localparam int HALVES       = FREQ_W / DATA_W,
   localparam int N_FREQ_SLOTS = N_FREQ * HALVES,
   localparam int N_SLOTS      = N_FREQ_SLOTS + N_PHASE,
   localparam int ADDR_W       = addr_bits(N_SLOTS)
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_n,
   input  logic [DATA_W-1:0]                bus_data,
   input  logic [ADDR_W-1:0]                bus_addr,
   output logic [N_FREQ-1:0][FREQ_W-1:0]    freq_word,
   output logic [N_PHASE-1:0][PHASE_W-1:0]  phase_word
);

   if (FREQ_W % DATA_W != 0) begin : g_bad_freq
      $error("FREQ_W must be a multiple of DATA_W");
   end
   if (PHASE_W > DATA_W || PHASE_W < 1) begin : g_bad_phase
      $error("PHASE_W must lie in 1..DATA_W");
   end
   if (N_FREQ < 1 || N_PHASE < 1) begin : g_bad_count
      $error("at least one frequency and one phase register required");
   end

   logic               commit;
   logic [DATA_W-1:0]  held_data;
   logic [ADDR_W-1:0]  held_addr;
   logic [N_SLOTS-1:0] slot_we;

   ldr_strobe_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_n      (wr_n),
      .bus_data  (bus_data),
      .bus_addr  (bus_addr),
      .commit    (commit),
      .held_data (held_data),
      .held_addr (held_addr)
   );

   ldr_slot_decode #(.ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS)) i_decode (
      .commit    (commit),
      .held_addr (held_addr),
      .slot_we   (slot_we)
   );

   ldr_word_store #(
      .DATA_W(DATA_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W),
      .N_FREQ(N_FREQ), .N_PHASE(N_PHASE)
   ) i_store (
      .clk        (clk),
      .slot_we    (slot_we),
      .held_data  (held_data),
      .freq_word  (freq_word),
      .phase_word (phase_word)
   );

endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
   parameter int DATA_W       = 16,
   parameter int FREQ_W       = 32,
   parameter int PHASE_W      = 12,
   parameter int N_FREQ       = 2,
   parameter int N_PHASE      = 4,
   parameter int ADDR_W       = 3,
   localparam int HALVES       = FREQ_W / DATA_W,
   localparam int N_FREQ_SLOTS = N_FREQ * HALVES,
   localparam int N_SLOTS      = N_FREQ_SLOTS + N_PHASE
)(
   input logic                             clk,
   input logic                             rst_n,
   input logic                             commit,
   input logic [N_SLOTS-1:0]               slot_we,
   input logic [DATA_W-1:0]                held_data,
   input logic [ADDR_W-1:0]                held_addr,
   input logic [N_FREQ-1:0][FREQ_W-1:0]    freq_word,
   input logic [N_PHASE-1:0][PHASE_W-1:0]  phase_word
);

   AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_we)); // R3

   AST_COMMIT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      commit && (int'(held_addr) < N_SLOTS) |-> slot_we[held_addr]); // R2

   AST_NO_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |-> (slot_we == '0)); // R8

   for (genvar s = 0; s < N_FREQ_SLOTS; s++) begin : g_freq_chk
      AST_FREQ_HALF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         slot_we[s] |=> freq_word[s / HALVES][(s % HALVES) * DATA_W +: DATA_W]
                        == $past(held_data)); // R2
   end

   for (genvar p = 0; p < N_PHASE; p++) begin : g_phase_chk
      AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         slot_we[N_FREQ_SLOTS + p] |=> phase_word[p]
                        == $past(held_data[PHASE_W-1:0])); // R4
   end

endmodule

bind ctrl_word_loader ldr_checker #(
   .DATA_W(DATA_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W),
   .N_FREQ(N_FREQ), .N_PHASE(N_PHASE), .ADDR_W(ADDR_W)
) i_ldr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .commit     (commit),
   .slot_we    (slot_we),
   .held_data  (held_data),
   .held_addr  (held_addr),
   .freq_word  (freq_word),
   .phase_word (phase_word)
);

// File: tb/test_ctrl_word_loader.sv
`timescale 1ns/100ps
module test_ctrl_word_loader;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              wr_n = 1'b1;
   logic [15:0]       bus_data = '0;
   logic [2:0]        bus_addr = '0;
   logic [1:0][31:0]  freq_word;
   logic [3:0][11:0]  phase_word;

   ctrl_word_loader i_ctrl_word_loader (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .bus_data(bus_data),
      .bus_addr(bus_addr), .freq_word(freq_word), .phase_word(phase_word)
   );

   typedef struct {
      int          due;
      int          ri;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   int          cyc = 0;
   int          errors = 0;
   int          checks = 0;
   bit          done = 0;
   logic [31:0] mf [2];
   logic [11:0] mp [4];

   always @(posedge clk) cyc <= cyc + 1;

   // Register index: 0,1 = frequency steps; 2..5 = phase offsets.
   function automatic int reg_of(input logic [2:0] a);
      return (a < 4) ? int'(a) / 2 : int'(a) - 2;
   endfunction

   function automatic logic [31:0] dut_reg(input int ri);
      return (ri < 2) ? freq_word[ri] : {20'd0, phase_word[ri-2]};
   endfunction

   function automatic logic [31:0] model_reg(input int ri);
      return (ri < 2) ? mf[ri] : {20'd0, mp[ri-2]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int ri = 0; ri < 6; ri++) chk(tag, dut_reg(ri), model_reg(ri));
   endtask

   // Driver: short strobe inside one cycle, then scramble the bus (R1).
   task automatic wr(input logic [2:0] a, input logic [15:0] d,
                     input string tag, input bit pre);
      int ri;
      @(negedge clk);
      bus_addr = a;
      bus_data = d;
      wr_n = 1'b0;
      #1 wr_n = 1'b1;
      #0.5;
      bus_data = ~d;
      bus_addr = a + 3'd3;
      ri = reg_of(a);
      if (pre) chk({tag, " R5 before commit edge"}, dut_reg(ri), model_reg(ri));
      if (a < 4) begin
         if (a[0]) mf[a[1]][31:16] = d;
         else      mf[a[1]][15:0]  = d;
      end else begin
         mp[a - 3'd4] = d[11:0];
      end
      sb_q.push_back('{cyc + 1, ri, model_reg(ri), tag});
   endtask

   // Monitor: compare each expected item on the cycle it is due.
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         item_t it;
         it = sb_q.pop_front();
         if (it.due != cyc) begin
            checks++;
            errors++;
            $display("FAIL %s R5: actual=late expected=cycle %0d", it.tag, it.due);
         end else begin
            chk(it.tag, dut_reg(it.ri), it.exp);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // Known starting state: clear every address (R2, R4)
      for (int a = 0; a < 8; a++) wr(3'(a), 16'h0000, "R2 clear", 0);
      repeat (2) @(negedge clk);
      check_all("R2 cleared state");

      // R2/R3: assemble step 0 low first, step 1 high first
      wr(3'd0, 16'h1234, "R2 f0 low", 1);
      wr(3'd1, 16'hABCD, "R2 f0 high", 1);
      wr(3'd3, 16'h5A5A, "R2 f1 high", 1);
      wr(3'd2, 16'hC3C3, "R2 f1 low", 1);
      repeat (2) @(negedge clk);
      chk("R2 f0 assembled", freq_word[0], 32'hABCD_1234);
      chk("R2 f1 assembled", freq_word[1], 32'h5A5A_C3C3);
      // R3: rewrite one half only
      wr(3'd0, 16'hFFFF, "R3 f0 low rewrite", 1);
      repeat (2) @(negedge clk);
      chk("R3 f0 high kept", freq_word[0], 32'hABCD_FFFF);

      // R4: upper four data bits dropped
      wr(3'd4, 16'hF123, "R4 ph0", 1);
      wr(3'd5, 16'hA456, "R4 ph1", 1);
      wr(3'd6, 16'h5789, "R4 ph2", 1);
      wr(3'd7, 16'hFABC, "R4 ph3", 1);
      repeat (2) @(negedge clk);
      chk("R4 ph0 truncated", {20'd0, phase_word[0]}, 32'h123);
      chk("R4 ph3 truncated", {20'd0, phase_word[3]}, 32'hABC);

      // R6: one write per cycle over all addresses
      for (int a = 0; a < 8; a++) wr(3'(7 - a), 16'(16'h1111 * (a + 1)), "R6 burst", 1);
      repeat (2) @(negedge clk);
      check_all("R6 after burst");

      // R8: bus noise without a strobe
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         bus_data = 16'($urandom);
         bus_addr = 3'($urandom);
      end
      repeat (2) @(negedge clk);
      check_all("R8 idle bus");

      // R7: reset pulse keeps stored words
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_all("R7 during reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_all("R7 after reset");

      // R1: random traffic, bus scrambled after every strobe
      for (int k = 0; k < 40; k++) wr(3'($urandom), 16'($urandom), "R1 random", 1);
      repeat (3) @(negedge clk);
      check_all("R1 random final");
      chk("R5 scoreboard drained", 32'(sb_q.size()), 32'd0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule